// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds a small set of outgoing CAN frames for a controller and decides which of them goes to the bit-level transmitter next. Each mailbox stores an identifier (standard or extended), a data length code and eight data bytes. Software fills an empty mailbox through a word-wide write port and raises the request bit. From then on the mailbox is locked against writes until it is empty again.

While no frame is on its way, the scheduler looks at every pending mailbox on every clock and names one as scheduled. It uses one of two policies. In identifier mode the smallest arbitration key wins. In request-order mode the oldest request wins. When the bus is reported idle and no debug freeze applies, the scheduled frame is copied into an output register and offered to the transmitter over a valid/ready handshake. The transmitter later returns one result word. On success the mailbox is released and flagged. On failure the mailbox is either queued again or released, depending on a retry control.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every mailbox is empty, all status flags are clear, `fr_valid` is low and `sched_valid` is low.
- R2: A write to field 0 (`wr_field`=0) of an empty mailbox with `wr_data[30]` set stores the identifier and makes the mailbox pending at the next clock. In that write, `wr_data[29]` = 1 means extended (`wr_data[28:0]`) and 0 means standard (`wr_data[10:0]`). The same request clears that mailbox's four status flags.
- R3: While a mailbox is not empty, writes to its identifier (field 0), length (field 1, `wr_data[3:0]`), low data word (field 2, frame bytes in `fr_data[31:0]`) and high data word (field 3, `fr_data[63:32]`) have no effect, and a request bit in such a write is ignored.
- R4: With `order_mode`=0, the pending mailbox with the smallest key is scheduled. An extended identifier is its own key. A standard identifier's key is that identifier shifted left by 18 bits.
- R5: With `order_mode`=0 and equal keys, the lower mailbox index is scheduled first.
- R6: With `order_mode`=1, pending mailboxes are scheduled in the order their requests were accepted. A retried mailbox keeps its place.
- R7: The choice is re-made every clock while no frame is in flight. A frame is launched (`fr_valid` rises, with `fr_mb` naming the mailbox) only on a clock where `bus_idle` is high, a mailbox is scheduled and no other frame is in flight.
- R8: A result with `res_ok`=1 returns the mailbox to empty and sets its `tx_done` and `tx_ok` flags.
- R9: A result with `res_ok`=0 sets `arb_lost` when `res_arb_lost`=1 and `tx_err` when `res_err`=1. With `no_retry`=0 the mailbox becomes pending again and is relaunched.
- R10: With `no_retry`=1, a failed result returns the mailbox to empty, sets `tx_done` and leaves `tx_ok` clear.
- R11: While `dbg_freeze_en` and `dbg_halt` are both high, no new frame is launched. With `dbg_freeze_en` low, `dbg_halt` has no effect.
- R12: `fr_valid` and the frame fields stay constant until `fr_ready` is seen. A result offered before that handshake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_mb | input | MB_W | Target mailbox index |
| wr_field | input | 2 | 0 identifier/request, 1 length, 2 low data word, 3 high data word |
| wr_data | input | WORD_W | Write data |
| order_mode | input | 1 | 0 key order, 1 request order |
| no_retry | input | 1 | Release mailbox after a failure instead of retrying |
| dbg_freeze_en | input | 1 | Lets `dbg_halt` block launches |
| dbg_halt | input | 1 | Debug halt indication |
| bus_idle | input | 1 | Bus idle report from transmitter |
| fr_valid | output | 1 | Frame offered to transmitter |
| fr_ready | input | 1 | Transmitter takes the frame |
| fr_mb | output | MB_W | Source mailbox of the frame |
| fr_id | output | EXT_W | Identifier (standard in low 11 bits) |
| fr_ext | output | 1 | Extended identifier flag |
| fr_dlc | output | DLC_W | Data length code |
| fr_data | output | DATA_W | Data bytes |
| res_valid | input | 1 | Result strobe from transmitter |
| res_ok | input | 1 | Frame sent successfully |
| res_arb_lost | input | 1 | Arbitration lost |
| res_err | input | 1 | Transmit error |
| mb_empty | output | NUM_MB | Mailbox empty per index |
| tx_done | output | NUM_MB | Request completed per mailbox |
| tx_ok | output | NUM_MB | Completed successfully per mailbox |
| arb_lost | output | NUM_MB | Arbitration lost seen per mailbox |
| tx_err | output | NUM_MB | Transmit error seen per mailbox |
| sched_valid | output | 1 | A mailbox is scheduled |
| sched_mb | output | MB_W | Index of the scheduled mailbox |

## Verification
The bench mixes standard and extended identifiers. This includes a standard identifier whose shifted key equals an extended one, which catches a design that compares raw identifier values or breaks ties toward the higher index. In request-order mode it loads mailboxes out of index order and drains them one by one. A design that loses the age ranks when a mailbox leaves would reorder the later frames. It overwrites a pending mailbox, which exposes a design that does not lock the mailbox, because the new contents would appear on the frame port. It holds the handshake back while a result is offered, which exposes a design that accepts results early, because the mailbox would be freed before the handshake. It also covers a higher-priority request arriving after another has been scheduled, failure retry versus release, and the freeze gating.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

   typedef enum logic [1:0] {
      MB_EMPTY = 2'd0,
      MB_PEND  = 2'd1,
      MB_TX    = 2'd2
   } mb_state_e;

   typedef enum logic [1:0] {
      FLD_ID  = 2'd0,
      FLD_LEN = 2'd1,
      FLD_DLO = 2'd2,
      FLD_DHI = 2'd3
   } fld_e;

   localparam int EXT_BIT = 29;
   localparam int REQ_BIT = 30;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
   import can_txmb_pkg::*;
#(
   parameter int EXT_W  = 29,
   parameter int STD_W  = 11,
   parameter int DLC_W  = 4,
   parameter int WORD_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [1:0]        wr_field,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              launch,
   input  logic              res_accept,
   input  logic              res_ok,
   input  logic              res_al,
   input  logic              res_er,
   input  logic              no_retry,
   output mb_state_e         state,
   output logic [EXT_W-1:0]  id,
   output logic              ext,
   output logic [DLC_W-1:0]  dlc,
   output logic [DATA_W-1:0] data,
   output logic              f_done,
   output logic              f_ok,
   output logic              f_al,
   output logic              f_er,
   output logic              req_fire,
   output logic              leave
);

   mb_state_e         st_q;
   logic [EXT_W-1:0]  id_q;
   logic              ext_q;
   logic [DLC_W-1:0]  dlc_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q, ok_q, al_q, er_q;
   logic              open_w, fire;

   assign open_w   = wr_hit && (st_q == MB_EMPTY);
   assign req_fire = open_w && (wr_field == FLD_ID) && wr_data[REQ_BIT];
   assign fire     = res_accept && (st_q == MB_TX);
   assign leave    = fire && (res_ok || no_retry);

   // contents: writable only while empty
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q   <= '0;
         ext_q  <= 1'b0;
         dlc_q  <= '0;
         data_q <= '0;
      end else if (open_w) begin
         case (wr_field)
            FLD_ID: begin
               ext_q <= wr_data[EXT_BIT];
               id_q  <= wr_data[EXT_BIT] ? wr_data[EXT_W-1:0]
                                         : {{(EXT_W-STD_W){1'b0}}, wr_data[STD_W-1:0]};
            end
            FLD_LEN: dlc_q <= wr_data[DLC_W-1:0];
            FLD_DLO: data_q[WORD_W-1:0] <= wr_data;
            default: data_q[DATA_W-1:WORD_W] <= wr_data;
         endcase
      end
   end

   // lifecycle and status flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= MB_EMPTY;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         al_q   <= 1'b0;
         er_q   <= 1'b0;
      end else begin
         case (st_q)
            MB_EMPTY: if (req_fire) begin
               st_q   <= MB_PEND;
               done_q <= 1'b0;
               ok_q   <= 1'b0;
               al_q   <= 1'b0;
               er_q   <= 1'b0;
            end
            MB_PEND: if (launch) st_q <= MB_TX;
            MB_TX: if (fire) begin
               if (res_ok) begin
                  st_q   <= MB_EMPTY;
                  done_q <= 1'b1;
                  ok_q   <= 1'b1;
               end else begin
                  al_q <= al_q | res_al;
                  er_q <= er_q | res_er;
                  if (no_retry) begin
                     st_q   <= MB_EMPTY;
                     done_q <= 1'b1;
                     ok_q   <= 1'b0;
                  end else begin
                     st_q <= MB_PEND;
                  end
               end
            end
            default: st_q <= MB_EMPTY;
         endcase
      end
   end

   assign state  = st_q;
   assign id     = id_q;
   assign ext    = ext_q;
   assign dlc    = dlc_q;
   assign data   = data_q;
   assign f_done = done_q;
   assign f_ok   = ok_q;
   assign f_al   = al_q;
   assign f_er   = er_q;

   assert_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> (st_q == MB_PEND) && !done_q && !ok_q && !al_q && !er_q);

   assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != MB_EMPTY) |=> $stable(id_q) && $stable(ext_q) && $stable(dlc_q) && $stable(data_q));

   assert_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && res_ok) |=> (st_q == MB_EMPTY) && done_q && ok_q);

   assert_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !res_ok && !no_retry) |=> (st_q == MB_PEND));

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !res_ok && no_retry) |=> (st_q == MB_EMPTY) && done_q && !ok_q);

endmodule

// File: rtl/can_txmb_order.sv
module can_txmb_order #(
   parameter int NUM    = 3,
   parameter int RANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM-1:0]    busy,
   input  logic [NUM-1:0]    req_fire,
   input  logic [NUM-1:0]    leave,
   output logic [RANK_W-1:0] rank [NUM]
);

   logic [RANK_W-1:0] rank_q [NUM];
   logic [RANK_W-1:0] leave_rank;
   logic [RANK_W-1:0] stay_cnt;
   logic              leave_any;

   always_comb begin
      int cnt;
      cnt        = 0;
      leave_rank = '0;
      for (int i = 0; i < NUM; i++) begin
         if (busy[i] && !leave[i]) cnt++;
         if (leave[i]) leave_rank = rank_q[i];
      end
      stay_cnt  = RANK_W'(cnt);
      leave_any = |leave;
   end

   for (genvar i = 0; i < NUM; i++) begin : g_rank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rank_q[i] <= '0;
         end else if (req_fire[i]) begin
            rank_q[i] <= stay_cnt;
         end else if (busy[i] && !leave[i] && leave_any && (rank_q[i] > leave_rank)) begin
            rank_q[i] <= rank_q[i] - 1'b1;
         end
      end
      assign rank[i] = rank_q[i];

      for (genvar j = i + 1; j < NUM; j++) begin : g_pair
         assert_unique_rank_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[i] && busy[j]) |-> (rank_q[i] != rank_q[j]));
      end
   end

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb #(
   parameter int NUM      = 3,
   parameter int EXT_W    = 29,
   parameter int STD_W    = 11,
   parameter int RANK_W   = 2,
   parameter int MB_W     = 2,
   parameter bit ORDER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM-1:0]    pend,
   input  logic [EXT_W-1:0]  id_a   [NUM],
   input  logic              ext_a  [NUM],
   input  logic [RANK_W-1:0] rank_a [NUM],
   input  logic              order_mode,
   output logic              win_valid,
   output logic [MB_W-1:0]   win_idx
);

   logic [EXT_W-1:0]  key [NUM];
   logic [EXT_W-1:0]  win_key;
   logic [RANK_W-1:0] win_rank;
   logic              use_order;

   for (genvar i = 0; i < NUM; i++) begin : g_key
      assign key[i] = ext_a[i] ? id_a[i] : {id_a[i][STD_W-1:0], {(EXT_W-STD_W){1'b0}}};
   end

   if (ORDER_EN) begin : g_order
      assign use_order = order_mode;
   end else begin : g_keyonly
      logic unused_order;
      assign unused_order = order_mode;
      assign use_order    = 1'b0;
   end

   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_key   = '1;
      win_rank  = '1;
      for (int i = 0; i < NUM; i++) begin
         if (pend[i]) begin
            if (!win_valid || (use_order ? (rank_a[i] < win_rank) : (key[i] < win_key))) begin
               win_valid = 1'b1;
               win_idx   = MB_W'(i);
               win_key   = key[i];
               win_rank  = rank_a[i];
            end
         end
      end
   end

   for (genvar j = 0; j < NUM; j++) begin : g_chk
      assert_lowest_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && !use_order && pend[j]) |-> (win_key <= key[j]));
      assert_tie_low_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && !use_order && pend[j] && (key[j] == win_key)) |-> (win_idx <= MB_W'(j)));
      assert_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && use_order && pend[j]) |-> (win_rank <= rank_a[j]));
   end

endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
   import can_txmb_pkg::*;
#(
   parameter int  NUM_MB   = 3,
   parameter int  EXT_W    = 29,
   parameter int  STD_W    = 11,
   parameter int  DLC_W    = 4,
   parameter int  WORD_W   = 32,
   parameter int  DATA_W   = 64,
   parameter bit  ORDER_EN = 1'b1,
   localparam int MB_W     = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
   localparam int RANK_W   = MB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MB_W-1:0]   wr_mb,
   input  logic [1:0]        wr_field,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              order_mode,
   input  logic              no_retry,
   input  logic              dbg_freeze_en,
   input  logic              dbg_halt,
   input  logic              bus_idle,
   output logic              fr_valid,
   input  logic              fr_ready,
   output logic [MB_W-1:0]   fr_mb,
   output logic [EXT_W-1:0]  fr_id,
   output logic              fr_ext,
   output logic [DLC_W-1:0]  fr_dlc,
   output logic [DATA_W-1:0] fr_data,
   input  logic              res_valid,
   input  logic              res_ok,
   input  logic              res_arb_lost,
   input  logic              res_err,
   output logic [NUM_MB-1:0] mb_empty,
   output logic [NUM_MB-1:0] tx_done,
   output logic [NUM_MB-1:0] tx_ok,
   output logic [NUM_MB-1:0] arb_lost,
   output logic [NUM_MB-1:0] tx_err,
   output logic              sched_valid,
   output logic [MB_W-1:0]   sched_mb
);

   // elaboration-time parameter checks
   if (NUM_MB < 2 || NUM_MB > 8) begin : g_bad_num
      $error("can_txmb_sched: NUM_MB must lie in 2..8");
   end
   if (DATA_W != 2 * WORD_W) begin : g_bad_data
      $error("can_txmb_sched: DATA_W must be twice WORD_W");
   end
   if (EXT_W <= STD_W || WORD_W < REQ_BIT + 1) begin : g_bad_id
      $error("can_txmb_sched: identifier widths do not fit the write word");
   end

   mb_state_e         st_a   [NUM_MB];
   logic [EXT_W-1:0]  id_a   [NUM_MB];
   logic              ext_a  [NUM_MB];
   logic [DLC_W-1:0]  dlc_a  [NUM_MB];
   logic [DATA_W-1:0] data_a [NUM_MB];
   logic [RANK_W-1:0] rank_a [NUM_MB];
   logic [NUM_MB-1:0] pend_v, tx_v, busy_v, req_v, leave_v, launch_v;

   logic              win_valid;
   logic [MB_W-1:0]   win_idx;
   logic              tx_active, frozen, launch, res_accept;

   assign tx_active  = |tx_v;
   assign frozen     = dbg_freeze_en && dbg_halt;
   assign launch     = win_valid && !tx_active && bus_idle && !frozen;
   assign res_accept = res_valid && tx_active && !fr_valid;

   for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
      can_txmb_slot #(
         .EXT_W (EXT_W),
         .STD_W (STD_W),
         .DLC_W (DLC_W),
         .WORD_W(WORD_W),
         .DATA_W(DATA_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hit    (wr_en && (wr_mb == MB_W'(i))),
         .wr_field  (wr_field),
         .wr_data   (wr_data),
         .launch    (launch_v[i]),
         .res_accept(res_accept),
         .res_ok    (res_ok),
         .res_al    (res_arb_lost),
         .res_er    (res_err),
         .no_retry  (no_retry),
         .state     (st_a[i]),
         .id        (id_a[i]),
         .ext       (ext_a[i]),
         .dlc       (dlc_a[i]),
         .data      (data_a[i]),
         .f_done    (tx_done[i]),
         .f_ok      (tx_ok[i]),
         .f_al      (arb_lost[i]),
         .f_er      (tx_err[i]),
         .req_fire  (req_v[i]),
         .leave     (leave_v[i])
      );
      assign pend_v[i]   = (st_a[i] == MB_PEND);
      assign tx_v[i]     = (st_a[i] == MB_TX);
      assign busy_v[i]   = (st_a[i] != MB_EMPTY);
      assign mb_empty[i] = (st_a[i] == MB_EMPTY);
      assign launch_v[i] = launch && (win_idx == MB_W'(i));
   end

   can_txmb_order #(
      .NUM   (NUM_MB),
      .RANK_W(RANK_W)
   ) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy_v),
      .req_fire(req_v),
      .leave   (leave_v),
      .rank    (rank_a)
   );

   can_txmb_arb #(
      .NUM     (NUM_MB),
      .EXT_W   (EXT_W),
      .STD_W   (STD_W),
      .RANK_W  (RANK_W),
      .MB_W    (MB_W),
      .ORDER_EN(ORDER_EN)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend_v),
      .id_a      (id_a),
      .ext_a     (ext_a),
      .rank_a    (rank_a),
      .order_mode(order_mode),
      .win_valid (win_valid),
      .win_idx   (win_idx)
   );

   assign sched_valid = win_valid && !tx_active;
   assign sched_mb    = win_idx;

   // frame select and output register
   logic [EXT_W-1:0]  sel_id;
   logic              sel_ext;
   logic [DLC_W-1:0]  sel_dlc;
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      sel_id   = '0;
      sel_ext  = 1'b0;
      sel_dlc  = '0;
      sel_data = '0;
      for (int i = 0; i < NUM_MB; i++) begin
         if (win_idx == MB_W'(i)) begin
            sel_id   = id_a[i];
            sel_ext  = ext_a[i];
            sel_dlc  = dlc_a[i];
            sel_data = data_a[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fr_valid <= 1'b0;
         fr_mb    <= '0;
         fr_id    <= '0;
         fr_ext   <= 1'b0;
         fr_dlc   <= '0;
         fr_data  <= '0;
      end else if (launch) begin
         fr_valid <= 1'b1;
         fr_mb    <= win_idx;
         fr_id    <= sel_id;
         fr_ext   <= sel_ext;
         fr_dlc   <= sel_dlc;
         fr_data  <= sel_data;
      end else if (fr_valid && fr_ready) begin
         fr_valid <= 1'b0;
      end
   end

   assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_v));

   assert_launch_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fr_valid) |-> $past(bus_idle) && !$past(tx_active));

   assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fr_valid) |-> !$past(frozen));

   assert_frame_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_valid && !fr_ready) |=> fr_valid && $stable(fr_mb) && $stable(fr_id)
                                  && $stable(fr_dlc) && $stable(fr_data));

   assert_valid_in_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fr_valid |-> tx_active);

endmodule

// File: tb/can_txmb_sched_bench.sv
`timescale 1ns/1ps
module can_txmb_sched_bench;

   localparam int NUM = 3;
   localparam logic [29:0] EXTF = 30'h2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_mb = '0;
   logic [1:0]  wr_field = '0;
   logic [31:0] wr_data = '0;
   logic        order_mode = 1'b0, no_retry = 1'b0;
   logic        dbg_freeze_en = 1'b0, dbg_halt = 1'b0, bus_idle = 1'b0;
   logic        fr_valid, fr_ready = 1'b0;
   logic [1:0]  fr_mb;
   logic [28:0] fr_id;
   logic        fr_ext;
   logic [3:0]  fr_dlc;
   logic [63:0] fr_data;
   logic        res_valid = 1'b0, res_ok = 1'b0, res_arb_lost = 1'b0, res_err = 1'b0;
   logic [2:0]  mb_empty, tx_done, tx_ok, arb_lost, tx_err;
   logic        sched_valid;
   logic [1:0]  sched_mb;

   int n_tests = 0;
   int n_fail  = 0;
   bit ended   = 1'b0;

   always #5 clk = ~clk;

   can_txmb_sched u_can_txmb_sched (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mb(wr_mb), .wr_field(wr_field),
      .wr_data(wr_data), .order_mode(order_mode), .no_retry(no_retry),
      .dbg_freeze_en(dbg_freeze_en), .dbg_halt(dbg_halt), .bus_idle(bus_idle),
      .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_mb(fr_mb), .fr_id(fr_id),
      .fr_ext(fr_ext), .fr_dlc(fr_dlc), .fr_data(fr_data), .res_valid(res_valid),
      .res_ok(res_ok), .res_arb_lost(res_arb_lost), .res_err(res_err),
      .mb_empty(mb_empty), .tx_done(tx_done), .tx_ok(tx_ok), .arb_lost(arb_lost),
      .tx_err(tx_err), .sched_valid(sched_valid), .sched_mb(sched_mb)
   );

   // scheduling vectors: per case the mode, the three mailbox identifiers
   // (bit 29 = extended), the load sequence and the expected launch sequence
   localparam int NV = 6;
   localparam int          V_MODE [NV]    = '{0, 0, 0, 0, 1, 1};
   localparam logic [29:0] V_ID   [NV][3] = '{
      '{30'h100, 30'h050, 30'h200},
      '{30'h123, 30'h123, 30'h123},
      '{EXTF | 30'h1FFF_FFFF, 30'h001, EXTF | 30'h10},
      '{EXTF | 30'h4_0000, 30'h001, EXTF | 30'h3_FFFF},
      '{30'h300, 30'h100, 30'h200},
      '{30'h001, 30'h002, 30'h003}};
   localparam int V_LOAD [NV][3] = '{
      '{0, 1, 2}, '{2, 1, 0}, '{0, 1, 2}, '{1, 2, 0}, '{2, 0, 1}, '{1, 2, 0}};
   localparam int V_EXP  [NV][3] = '{
      '{1, 0, 2}, '{0, 1, 2}, '{2, 1, 0}, '{2, 0, 1}, '{2, 0, 1}, '{1, 2, 0}};

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int mb, input int fld, input logic [31:0] d);
      wr_en = 1'b1; wr_mb = 2'(mb); wr_field = 2'(fld); wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic load(input int mb, input logic [29:0] idw, input logic [3:0] dlc,
                       input logic [31:0] lo, input logic [31:0] hi);
      wr(mb, 1, {28'h0, dlc});
      wr(mb, 2, lo);
      wr(mb, 3, hi);
      wr(mb, 0, {2'b01, idw});
   endtask

   task automatic wait_frame();
      int n = 0;
      while (!fr_valid && n < 50) begin
         step();
         n++;
      end
      chk("R7 frame launched", 64'(fr_valid), 64'd1);
   endtask

   task automatic finish_tx(input logic ok, input logic al, input logic er);
      fr_ready = 1'b1;
      step();
      fr_ready = 1'b0;
      res_valid = 1'b1; res_ok = ok; res_arb_lost = al; res_err = er;
      step();
      res_valid = 1'b0; res_ok = 1'b0; res_arb_lost = 1'b0; res_err = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(); step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      chk("R1 mb_empty", 64'(mb_empty), 64'h7);
      chk("R1 tx_done", 64'(tx_done), 64'h0);
      chk("R1 tx_ok", 64'(tx_ok), 64'h0);
      chk("R1 err flags", 64'({arb_lost, tx_err}), 64'h0);
      chk("R1 fr_valid", 64'(fr_valid), 64'h0);
      chk("R1 sched_valid", 64'(sched_valid), 64'h0);

      // vector table: R4 R5 R6 ordering
      for (int v = 0; v < NV; v++) begin
         order_mode = V_MODE[v][0];
         bus_idle   = 1'b0;
         for (int k = 0; k < 3; k++) begin
            load(V_LOAD[v][k], V_ID[v][V_LOAD[v][k]], 4'(V_LOAD[v][k] + 1), 32'h0, 32'h0);
            chk("R2 pending after request", 64'(mb_empty[V_LOAD[v][k]]), 64'd0);
         end
         bus_idle = 1'b1;
         for (int k = 0; k < 3; k++) begin
            wait_frame();
            chk(V_MODE[v] == 1 ? "R6 request order" : "R4 R5 key order",
                64'(fr_mb), 64'(V_EXP[v][k]));
            chk("R4 frame id", 64'(fr_id), 64'(V_ID[v][V_EXP[v][k]][28:0]));
            chk("R2 frame ext", 64'(fr_ext), 64'(V_ID[v][V_EXP[v][k]][29]));
            finish_tx(1'b1, 1'b0, 1'b0);
         end
         chk("R8 all empty", 64'(mb_empty), 64'h7);
         chk("R8 done flags", 64'({tx_done, tx_ok}), 64'h3F);
      end
      order_mode = 1'b0;

      // R7: re-evaluation before launch, and no launch while bus busy
      bus_idle = 1'b0;
      load(0, 30'h200, 4'd1, 32'h0, 32'h0);
      chk("R2 request clears flags", 64'({tx_done[0], tx_ok[0]}), 64'h0);
      chk("R7 scheduled first", 64'({sched_valid, sched_mb}), 64'h4);
      load(2, 30'h100, 4'd1, 32'h0, 32'h0);
      chk("R7 displaced by newer", 64'({sched_valid, sched_mb}), 64'h6);
      step(); step();
      chk("R7 no launch when busy", 64'(fr_valid), 64'd0);
      bus_idle = 1'b1;
      wait_frame();
      chk("R7 launched winner", 64'(fr_mb), 64'd2);
      finish_tx(1'b1, 1'b0, 1'b0);
      wait_frame();
      chk("R7 then remaining", 64'(fr_mb), 64'd0);
      finish_tx(1'b1, 1'b0, 1'b0);

      // R12: handshake hold and early result ignored
      load(1, 30'h055, 4'd3, 32'h0, 32'h0);
      wait_frame();
      res_valid = 1'b1; res_ok = 1'b1;
      step(); step(); step();
      res_valid = 1'b0; res_ok = 1'b0;
      chk("R12 valid held", 64'(fr_valid), 64'd1);
      chk("R12 id held", 64'(fr_id), 64'h55);
      chk("R12 early result ignored", 64'({mb_empty[1], tx_done[1]}), 64'h0);
      finish_tx(1'b1, 1'b0, 1'b0);
      chk("R8 released", 64'({mb_empty[1], tx_done[1], tx_ok[1]}), 64'h7);

      // R3: writes to a locked mailbox have no effect
      bus_idle = 1'b0;
      load(1, 30'h010, 4'd2, 32'hA1A2A3A4, 32'hB1B2B3B4);
      wr(1, 1, 32'h8);
      wr(1, 2, 32'h0);
      wr(1, 3, 32'hFFFF_FFFF);
      wr(1, 0, {2'b01, EXTF | 30'h7FF});
      bus_idle = 1'b1;
      wait_frame();
      chk("R3 id kept", 64'({fr_ext, fr_id}), 64'h10);
      chk("R3 dlc kept", 64'(fr_dlc), 64'd2);
      chk("R3 data kept", fr_data, 64'hB1B2B3B4_A1A2A3A4);
      finish_tx(1'b1, 1'b0, 1'b0);
      step(); step();
      chk("R3 request ignored", 64'({fr_valid, mb_empty[1]}), 64'h1);

      // R9: failures with retry
      no_retry = 1'b0;
      load(0, 30'h010, 4'd0, 32'h0, 32'h0);
      wait_frame();
      finish_tx(1'b0, 1'b1, 1'b0);
      chk("R9 arb lost flag", 64'({arb_lost[0], tx_err[0]}), 64'h2);
      chk("R9 still queued", 64'({mb_empty[0], tx_done[0]}), 64'h0);
      wait_frame();
      chk("R9 relaunched", 64'(fr_mb), 64'd0);
      finish_tx(1'b0, 1'b0, 1'b1);
      chk("R9 error flag", 64'({arb_lost[0], tx_err[0]}), 64'h3);
      wait_frame();
      finish_tx(1'b1, 1'b0, 1'b0);
      chk("R8 after retry", 64'({mb_empty[0], tx_done[0], tx_ok[0]}), 64'h7);

      // R10: failure without retry
      no_retry = 1'b1;
      load(2, 30'h020, 4'd0, 32'h0, 32'h0);
      wait_frame();
      finish_tx(1'b0, 1'b1, 1'b1);
      chk("R10 released", 64'({mb_empty[2], tx_done[2], tx_ok[2]}), 64'h6);
      chk("R10 cause flags", 64'({arb_lost[2], tx_err[2]}), 64'h3);
      step(); step();
      chk("R10 no relaunch", 64'(fr_valid), 64'd0);
      no_retry = 1'b0;

      // R11: debug freeze gating
      dbg_freeze_en = 1'b1; dbg_halt = 1'b1;
      load(0, 30'h005, 4'd0, 32'h0, 32'h0);
      repeat (5) step();
      chk("R11 frozen no launch", 64'(fr_valid), 64'd0);
      chk("R11 still scheduled", 64'({sched_valid, sched_mb}), 64'h4);
      dbg_freeze_en = 1'b0;
      wait_frame();
      chk("R11 halt ignored when disabled", 64'(fr_mb), 64'd0);
      finish_tx(1'b1, 1'b0, 1'b0);
      dbg_halt = 1'b0;

      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule